// File: doc/BRIEF.md
# Fetch Stall and Redirect Controller

This block is the front end of a 16-bit, five-stage in-order pipeline with an 8-bit program counter. It owns the program counter and the decode-stage instruction register. On every clock where the pipeline is running, it looks at the word just read from instruction memory and at the instructions held in the decode, execute and memory stages. From these it chooses one of three outcomes:

- accept the word and step the counter;
- hold the counter and feed a bubble into decode;
- load the counter with a branch target that was computed downstream.

A small run/idle state machine gates all of this. A start pulse with enable high sets it running. It drops back to idle when enable falls, or when a halt instruction reaches write-back.

The instruction format is as follows:

- opcode in bits [15:11];
- destination register in [10:8];
- first source register in [6:4];
- second source register in [2:0].

Every control-transfer opcode begins with the two bits 11, and no other opcode does. While such an instruction is in decode or execute, fetch is frozen. The transfer resolves when the instruction reaches the memory stage.

Top module: `fetch_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the counter, the decode word and the run state all clear to zero / idle.
- R2: In idle, `pc` and `dec_ir` do not change. Idle becomes running at an edge where `enable` and `start` are both 1, and the counter first moves on the edge after that.
- R3: Running returns to idle at an edge where `enable` is 0, or where the write-back opcode is HALT (00001). From the next edge on, `pc` and `dec_ir` hold.
- R4: The fetched opcode may be one of ADD 01000, ADDC 10001, SUB 01011, SUBC 10111, CMP 01100, AND 01101, OR 01111 or XOR 01110. If a LOAD (00010) sits in decode or execute and its [10:8] equals the fetched [6:4] or the fetched [2:0], the cycle stalls.
- R5: The fetched opcode may be one of SLL 00100, SRL 00110, SLA 00101, SRA 00111 or STORE 00011. Then a stall is raised only when a LOAD's [10:8] equals the fetched [6:4]; a match on [2:0] alone does not stall.
- R6: A decode or execute instruction whose bits [15:14] are 11 stalls fetch.
- R7: In a stall cycle, `pc` keeps its value and `dec_ir` becomes 0x0000, which is the NOP bubble.
- R8: Conditions are tested on the memory-stage opcode:
  - 11000 and 11001 are always taken;
  - 11010 is taken on zero and 11011 on not-zero;
  - 11100 is taken on negative and 11101 on not-negative;
  - 11110 is taken on carry and 11111 on not-carry.
- R9: When a branch is taken, `pc` receives `br_target[7:0]` and `dec_ir` becomes 0x0000.
- R10: With no stall and no taken branch, `dec_ir` takes the fetched word and `pc` increments by one, wrapping from 0xFF to 0x00.
- R11: If a stall and a taken memory-stage branch coincide, the stall wins: `pc` holds and the target is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run permission |
| start | input | 1 | Start request from idle |
| fetch_word | input | 16 | Word read from instruction memory at `pc` |
| exe_ir | input | 16 | Instruction in execute stage |
| mem_ir | input | 16 | Instruction in memory stage |
| wb_ir | input | 16 | Instruction in write-back stage |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| br_target | input | 16 | Computed branch target; low 8 bits used |
| pc | output | 8 | Program counter |
| dec_ir | output | 16 | Decode-stage instruction register |

## Verification
A stall and a taken memory-stage branch can fall in the same cycle. The bench provokes this on purpose: a jump sits in execute, or a LOAD hazard is fetched, while the memory stage holds a branch whose condition is true. The check then expects the counter to hold and a bubble to enter, not a redirect. Random runs also reach this overlap. There, a bench-side model ranks stall above redirect, and every cycle the model is compared with `pc` and `dec_ir`.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'b00000, OP_HALT = 5'b00001, OP_LOAD = 5'b00010, OP_STORE = 5'b00011,
        OP_SLL  = 5'b00100, OP_SLA  = 5'b00101, OP_SRL  = 5'b00110, OP_SRA   = 5'b00111,
        OP_ADD  = 5'b01000, OP_SUB  = 5'b01011, OP_CMP  = 5'b01100, OP_AND   = 5'b01101,
        OP_XOR  = 5'b01110, OP_OR   = 5'b01111, OP_ADDC = 5'b10001, OP_SUBC  = 5'b10111,
        OP_JMP  = 5'b11000, OP_JMPI = 5'b11001, OP_BRZ  = 5'b11010, OP_BRNZ  = 5'b11011,
        OP_BRN  = 5'b11100, OP_BRNN = 5'b11101, OP_BRC  = 5'b11110, OP_BRNC  = 5'b11111
    } opcode_e;

    typedef struct packed {
        logic [4:0] op;
        logic [2:0] rd;
        logic       pad_a;
        logic [2:0] rs;
        logic       pad_b;
        logic [2:0] rt;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
    localparam logic [INSTR_W-1:0] BUBBLE = '0;

    function automatic logic is_ctrl(input instr_t i);
        return i.op[4:3] == 2'b11;
    endfunction

    function automatic logic uses_two_src(input instr_t i);
        case (i.op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_AND, OP_OR, OP_XOR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic uses_first_src(input instr_t i);
        case (i.op)
            OP_SLL, OP_SRL, OP_SLA, OP_SRA, OP_STORE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic load_hits(input instr_t ld, input logic [2:0] r);
        return (ld.op == OP_LOAD) && (ld.rd == r);
    endfunction

endpackage

// File: rtl/fc_run_fsm.sv
module fc_run_fsm
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic start,
    input  logic [4:0] wb_op,
    output logic running
);
    typedef enum logic {ST_IDLE, ST_RUN} run_e;
    run_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (enable && start) st_d = ST_RUN;
            ST_RUN:  if (!enable || wb_op == OP_HALT) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign running = (st_q == ST_RUN);

    // R3: running drops once enable is removed
    a_r3_stop_on_disable: assert property (@(posedge clk) disable iff (rst)
        (running && !enable) |=> !running);
    // R2: idle only leaves on enable together with start
    a_r2_start_needs_both: assert property (@(posedge clk) disable iff (rst)
        (!running && !(enable && start)) |=> !running);
endmodule

// File: rtl/fc_hazard.sv
module fc_hazard
    import fc_pkg::*;
(
    input  instr_t fetched,
    input  instr_t dec,
    input  instr_t exe,
    output logic   stall
);
    localparam int N_STG = 2;
    instr_t stg [N_STG];
    logic [N_STG-1:0] hit_two, hit_one, ctrl_busy;

    assign stg[0] = dec;
    assign stg[1] = exe;

    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        assign hit_one[g]   = load_hits(stg[g], fetched.rs);
        assign hit_two[g]   = load_hits(stg[g], fetched.rs) || load_hits(stg[g], fetched.rt);
        assign ctrl_busy[g] = is_ctrl(stg[g]);
    end

    logic lu_stall;
    assign lu_stall = (uses_two_src(fetched) && |hit_two)
                   || (uses_first_src(fetched) && |hit_one);
    assign stall = lu_stall || |ctrl_busy;
endmodule

// File: rtl/fc_branch.sv
module fc_branch
    import fc_pkg::*;
(
    input  instr_t mem,
    input  logic   flag_z,
    input  logic   flag_n,
    input  logic   flag_c,
    output logic   taken
);
    logic cond;
    always_comb begin
        case (mem.op[2:1])
            2'b00:   cond = 1'b1;
            2'b01:   cond = flag_z;
            2'b10:   cond = flag_n;
            default: cond = flag_c;
        endcase
        if (mem.op[2:1] != 2'b00 && mem.op[0]) cond = !cond;
    end
    assign taken = is_ctrl(mem) && cond;
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fc_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int TGT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic [15:0]       fetch_word,
    input  logic [15:0]       exe_ir,
    input  logic [15:0]       mem_ir,
    input  logic [15:0]       wb_ir,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_c,
    input  logic [TGT_W-1:0]  br_target,
    output logic [PC_W-1:0]   pc,
    output logic [15:0]       dec_ir
);
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic running, stall, taken;
    logic [PC_W-1:0] pc_q;
    instr_t dec_q;

    fc_run_fsm u_run (
        .clk(clk), .rst(rst), .enable(enable), .start(start),
        .wb_op(wb_ir[15:11]), .running(running)
    );

    fc_hazard u_haz (
        .fetched(instr_t'(fetch_word)), .dec(dec_q), .exe(instr_t'(exe_ir)),
        .stall(stall)
    );

    fc_branch u_br (
        .mem(instr_t'(mem_ir)), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
        .taken(taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            dec_q <= BUBBLE;
        end else if (running) begin
            if (stall) begin
                dec_q <= BUBBLE;
            end else if (taken) begin
                pc_q  <= br_target[PC_W-1:0];
                dec_q <= BUBBLE;
            end else begin
                pc_q  <= pc_q + PC_ONE;
                dec_q <= instr_t'(fetch_word);
            end
        end
    end

    assign pc     = pc_q;
    assign dec_ir = dec_q;

    // R2: nothing moves while idle
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !running |=> ($stable(pc) && $stable(dec_ir)));
    // R7 R11: stall holds the counter and injects a bubble
    a_r7_stall_bubble: assert property (@(posedge clk) disable iff (rst)
        (running && stall) |=> (pc == $past(pc) && dec_ir == 16'h0000));
    // R9: taken branch loads the target
    a_r9_redirect: assert property (@(posedge clk) disable iff (rst)
        (running && !stall && taken) |=> (pc == $past(br_target[PC_W-1:0]) && dec_ir == 16'h0000));
    // R10: straight-line advance
    a_r10_advance: assert property (@(posedge clk) disable iff (rst)
        (running && !stall && !taken) |=> (pc == $past(pc) + PC_ONE && dec_ir == $past(fetch_word)));
    // R6: control word in decode always freezes fetch
    a_r6_ctrl_freeze: assert property (@(posedge clk) disable iff (rst)
        (running && dec_ir[15:14] == 2'b11) |=> (pc == $past(pc)));
endmodule

// File: tb/sim_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_ctrl;
    logic clk = 1'b0;
    logic rst, enable, start, fz, fn, fc;
    logic [15:0] fw, ex, me, wb, tgt;
    logic [7:0] pc;
    logic [15:0] dec;

    always #2.5 clk = ~clk;

    fetch_ctrl u0 (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .fetch_word(fw),
        .exe_ir(ex), .mem_ir(me), .wb_ir(wb), .flag_z(fz), .flag_n(fn), .flag_c(fc),
        .br_target(tgt), .pc(pc), .dec_ir(dec)
    );

    int checks = 0, fails = 0;
    bit m_run;
    logic [7:0] m_pc;
    logic [15:0] m_dec;

    function automatic logic [15:0] mk(input logic [4:0] op, input int rd, input int rs, input int rt);
        return {op, rd[2:0], 1'b0, rs[2:0], 1'b0, rt[2:0]};
    endfunction

    function automatic bit ld_dst(input logic [15:0] w, input logic [2:0] r);
        return w[15:11] == 5'b00010 && w[10:8] == r;
    endfunction

    // returns 4 (R4 stall), 5 (R5 stall), 6 (R6 stall) or 0
    function automatic int stall_kind(input logic [15:0] f, input logic [15:0] d, input logic [15:0] e);
        logic [4:0] o = f[15:11];
        bit two = (o == 5'b01000 || o == 5'b10001 || o == 5'b01011 || o == 5'b10111 ||
                   o == 5'b01100 || o == 5'b01101 || o == 5'b01111 || o == 5'b01110);
        bit one = (o == 5'b00100 || o == 5'b00110 || o == 5'b00101 || o == 5'b00111 || o == 5'b00011);
        if (two && (ld_dst(d, f[6:4]) || ld_dst(d, f[2:0]) || ld_dst(e, f[6:4]) || ld_dst(e, f[2:0]))) return 4;
        if (one && (ld_dst(d, f[6:4]) || ld_dst(e, f[6:4]))) return 5;
        if (d[15:14] == 2'b11 || e[15:14] == 2'b11) return 6;
        return 0;
    endfunction

    function automatic bit br_taken(input logic [15:0] m, input bit z, input bit n, input bit c);
        case (m[15:11])
            5'b11000, 5'b11001: return 1;
            5'b11010: return z;
            5'b11011: return !z;
            5'b11100: return n;
            5'b11101: return !n;
            5'b11110: return c;
            5'b11111: return !c;
            default:  return 0;
        endcase
    endfunction

    task automatic check(input string tag);
        checks++;
        if (pc !== m_pc || dec !== m_dec) begin
            fails++;
            $display("FAIL %s: pc=%h dec=%h expected pc=%h dec=%h", tag, pc, dec, m_pc, m_dec);
        end
    endtask

    task automatic step(input logic [15:0] f, e, m, w, input bit z, n, c,
                        input logic [15:0] t, input bit en, st, input string force_tag);
        string tag;
        int sk;
        bit tk;
        fw = f; ex = e; me = m; wb = w; fz = z; fn = n; fc = c; tgt = t; enable = en; start = st;
        sk = stall_kind(f, m_dec, e);
        tk = br_taken(m, z, n, c);
        if (!m_run) begin
            tag = "R2 idle hold";
        end else if (sk != 0) begin
            tag = (sk == 4) ? "R4 R7 load-use two-source" : (sk == 5) ? "R5 R7 load-use first-source"
                                                                      : "R6 R7 control in flight";
            m_dec = 16'h0000;
        end else if (tk) begin
            tag = "R8 R9 branch taken";
            m_pc = t[7:0]; m_dec = 16'h0000;
        end else begin
            tag = "R10 advance";
            m_pc = m_pc + 8'd1; m_dec = f;
        end
        if (force_tag != "") tag = force_tag;
        m_run = m_run ? (en && w[15:11] != 5'b00001) : (en && st);
        @(negedge clk);
        check(tag);
    endtask

    localparam logic [4:0] LD = 5'b00010, ADD = 5'b01000, SLL = 5'b00100, JMP = 5'b11000,
                           BZ = 5'b11010, HLT = 5'b00001, NOP = 5'b00000;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [4:0] pool [24];
        void'($urandom(32'd20417));
        for (int i = 0; i < 24; i++) pool[i] = 5'(i < 8 ? i : (i < 16 ? i + 0 : i + 8));
        rst = 1; enable = 0; start = 0; fw = 0; ex = 0; me = 0; wb = 0; fz = 0; fn = 0; fc = 0; tgt = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        m_run = 0; m_pc = 0; m_dec = 0;
        check("R1 reset state");
        // R2: start without enable keeps idle
        step(mk(ADD,1,2,3), 0, 0, 0, 0,0,0, 16'h0040, 0, 1, "R2 start without enable");
        step(mk(ADD,1,2,3), 0, 0, 0, 0,0,0, 16'h0040, 1, 1, "R2 start accepted, still frozen");
        step(mk(LD,2,0,0), 0, 0, 0, 0,0,0, 0, 1, 0, "R10 first advance");
        // R4: LOAD r2 in decode, ADD reads r2 via [2:0]
        step(mk(ADD,3,1,2), 0, 0, 0, 0,0,0, 0, 1, 0, "R4 stall on [2:0] match");
        // R5: LOAD r2 in execute, SLL with [2:0]=2 only: no stall
        step(mk(SLL,4,1,2), mk(LD,2,0,0), 0, 0, 0,0,0, 0, 1, 0, "R5 no stall on [2:0] only");
        step(mk(SLL,4,2,0), mk(LD,2,0,0), 0, 0, 0,0,0, 0, 1, 0, "R5 stall on [6:4]");
        // R11: jump in execute and taken branch in memory together
        step(mk(ADD,1,1,1), mk(JMP,0,0,0), mk(BZ,0,0,0), 0, 1,0,0, 16'h0077, 1, 0, "R11 stall beats branch");
        step(mk(ADD,1,1,1), 0, mk(BZ,0,0,0), 0, 0,0,0, 16'h0077, 1, 0, "R8 BZ not taken when z=0");
        step(mk(ADD,1,1,1), 0, mk(BZ,0,0,0), 0, 1,0,0, 16'h12FF, 1, 0, "R9 redirect to target low byte");
        step(mk(NOP,0,0,0), 0, 0, 0, 0,0,0, 0, 1, 0, "R10 wrap FF to 00");
        // R3: HALT in write-back stops the run
        step(mk(ADD,1,1,1), 0, 0, mk(HLT,0,0,0), 0,0,0, 0, 1, 0, "R3 last move before halt");
        step(mk(ADD,1,1,1), 0, 0, 0, 0,0,0, 0, 1, 0, "R3 frozen after halt");
        step(mk(ADD,1,1,1), 0, 0, 0, 0,0,0, 0, 1, 1, "R2 restart");
        step(mk(ADD,1,1,1), 0, 0, 0, 0,0,0, 0, 0, 0, "R3 enable low");
        step(mk(ADD,1,1,1), 0, 0, 0, 0,0,0, 0, 1, 0, "R3 frozen after enable low");
        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] f, e, m, w;
            f = mk(pool[$urandom % 24], $urandom % 4, $urandom % 4, $urandom % 4);
            e = ($urandom % 3 == 0) ? mk(LD, $urandom % 4, 0, 0) : mk(pool[$urandom % 24], $urandom % 4, 0, 0);
            m = ($urandom % 3 == 0) ? mk(5'b11000 | 5'($urandom % 8), 0, 0, 0) : 16'h0000;
            w = ($urandom % 50 == 0) ? mk(HLT, 0, 0, 0) : 16'h0000;
            if ($urandom % 8 == 0) e = 16'h0000;
            step(f, e, m, w, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                 ($urandom % 40) != 0, ($urandom % 3) == 0, "");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule